// File: doc/BRIEF.md
# Auto-Negotiation Page-Receive Status Registers

This block keeps the management-visible auto-negotiation state of one 10BASE-T port. Received 16-bit link code words arrive on a valid/ready stream. A small matcher watches consecutive accepted words. When the same word has been accepted three times in a row, the block raises a page-received flag and captures that word as the partner's advertised abilities. The block also keeps a sticky flag that records whether the partner has sent fast link pulses.

A register port with a 5-bit register number reads four registers: the partner ability word, an expansion status word, a next-page transmit register and a fixed identification word. A write to the next-page register stores the page. On the next cycle the block emits a one-cycle transmit request that carries that page. Reading the partner ability register acknowledges the page-received flag and clears it. Reading the expansion register leaves the flag alone.

The code-word stream never applies back-pressure after reset. `cw_ready` is low while reset is held and rises on the first clock edge after reset is released. From then on every cycle with `cw_valid` high delivers one word. Idle cycles between words do not break a run of identical words.

Top module: `an_page_status`

## Requirements
- R1: `cw_ready` is 0 during reset and 1 from the first rising edge after reset release onward; a word is taken on any edge where `cw_valid` and `cw_ready` are both high. After reset, the ability register, the next-page register and every flag read 0.
- R2: Expansion bit 1 (page received) becomes 1 on the edge that takes the third identical word in an unbroken run of taken words. Idle cycles do not break the run. A differing word restarts the run at one. A fourth or later repeat of the same word does not trigger again.
- R3: On the edge that sets page received, the ability register (address 0x05) captures the matched word.
- R4: A cycle with `reg_rd` high and address 0x05 clears page received at the next edge, while a read of 0x06 leaves it set. If the third matching word is taken in the same cycle as such a read, the set wins, and the read returns the previous ability value.
- R5: Expansion bit 0 becomes 1 at the first edge where `flp_seen` is high and stays 1 until reset.
- R6: Expansion bit 2 always reads 1, bit 3 equals bit 15 of the ability register, bit 4 equals the inverse of `link_up` in the same cycle, and bits 15..5 read 0.
- R7: Writes to addresses 0x05, 0x06, 0x10 or any unmapped address change no readable value and raise no transmit request.
- R8: A write to 0x07 stores `reg_wdata`; 0x07 then reads that value until the next write to 0x07. `np_tx_valid` is high for exactly the cycle after each such write, with `np_tx_page` equal to the written value.
- R9: Address 0x10 reads 0x0005 and unmapped addresses read 0. `reg_rdata` follows `reg_addr` combinationally, whether or not `reg_rd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cw_valid | input | 1 | Received code word present |
| cw_ready | output | 1 | Block accepts code words |
| cw_data | input | 16 | Received link code word |
| flp_seen | input | 1 | Fast link pulses detected from partner |
| link_up | input | 1 | Current link status |
| reg_addr | input | 5 | Register number |
| reg_rd | input | 1 | Read strobe (side effects only) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| np_tx_valid | output | 1 | One-cycle next-page transmit request |
| np_tx_page | output | 16 | Page to transmit (last written next page) |

## Verification
Two events can meet in the same cycle: the page-received flag can be set by the third matching code word while a read of the ability register tries to clear it. The bench provokes this on purpose. It sends two identical words, then drives the third word and a read of 0x05 in the same cycle. The read data must still show the old ability word. On the next cycle the expansion register must show the flag set and the new word captured. The reverse order, a read first and the completing word later, is also run, and there the flag must end up set after having been cleared.

// File: rtl/an_status_pkg.sv
package an_status_pkg;
  localparam int REG_ADDR_W = 5;
  localparam int REG_DATA_W = 16;

  localparam logic [REG_ADDR_W-1:0] ADDR_LP_ABIL = 5'h05;
  localparam logic [REG_ADDR_W-1:0] ADDR_EXPAN   = 5'h06;
  localparam logic [REG_ADDR_W-1:0] ADDR_NP_TX   = 5'h07;
  localparam logic [REG_ADDR_W-1:0] ADDR_DEV_ID  = 5'h10;

  typedef struct packed {
    logic [10:0] zero;
    logic        par_fault;
    logic        lp_np_able;
    logic        np_able;
    logic        page_rx;
    logic        lp_an_able;
  } expan_t;
endpackage

// File: rtl/an_cw_matcher.sv
module an_cw_matcher #(
  parameter int W   = 16,
  parameter int RUN = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic [W-1:0] word,
  output logic         hit
);
  localparam int CNT_W = $clog2(RUN + 1);
  localparam logic [CNT_W-1:0] RUN_C = CNT_W'(RUN);

  logic [W-1:0]     last_q;
  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] run_nx;
  logic             same;

  always_comb begin
    same = (run_q != '0) && (word == last_q);
    if (same)
      run_nx = (run_q == RUN_C) ? run_q : run_q + 1'b1;
    else
      run_nx = CNT_W'(1);
  end

  // fire once, on reaching the run length; saturated runs stay quiet
  assign hit = take && (run_nx == RUN_C) && (run_q != RUN_C);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= '0;
      run_q  <= '0;
    end else if (take) begin
      last_q <= word;
      run_q  <= run_nx;
    end
  end
endmodule

// File: rtl/an_lp_status.sv
module an_lp_status #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit,
  input  logic [W-1:0] word,
  input  logic         flp_seen,
  input  logic         clr_page,
  output logic         page_rx,
  output logic         lp_an,
  output logic [W-1:0] ability
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_rx <= 1'b0;
      lp_an   <= 1'b0;
      ability <= '0;
    end else begin
      if (hit) begin
        page_rx <= 1'b1;
        ability <= word;
      end else if (clr_page) begin
        page_rx <= 1'b0;
      end
      if (flp_seen)
        lp_an <= 1'b1;
    end
  end
endmodule

// File: rtl/an_np_tx.sv
module an_np_tx #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic         req,
  output logic [W-1:0] page
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req  <= 1'b0;
      page <= '0;
    end else begin
      req <= wr_en;
      if (wr_en)
        page <= wdata;
    end
  end
endmodule

// File: rtl/an_page_status.sv
module an_page_status
  import an_status_pkg::*;
#(
  parameter int MATCH_RUN = 3,
  parameter logic [REG_DATA_W-1:0] DEV_ID = 16'h0005
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cw_valid,
  output logic                  cw_ready,
  input  logic [REG_DATA_W-1:0] cw_data,
  input  logic                  flp_seen,
  input  logic                  link_up,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic                  reg_rd,
  input  logic                  reg_wr,
  input  logic [REG_DATA_W-1:0] reg_wdata,
  output logic [REG_DATA_W-1:0] reg_rdata,
  output logic                  np_tx_valid,
  output logic [REG_DATA_W-1:0] np_tx_page
);
  logic                  ready_q;
  logic                  take;
  logic                  hit;
  logic                  page_rx;
  logic                  lp_an;
  logic [REG_DATA_W-1:0] ability;
  logic [REG_DATA_W-1:0] np_page;
  expan_t                expan;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign cw_ready = ready_q;
  assign take     = cw_valid && ready_q;

  an_cw_matcher #(.W(REG_DATA_W), .RUN(MATCH_RUN)) u_match (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (take),
    .word  (cw_data),
    .hit   (hit)
  );

  an_lp_status #(.W(REG_DATA_W)) u_lp (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit),
    .word     (cw_data),
    .flp_seen (flp_seen),
    .clr_page (reg_rd && (reg_addr == ADDR_LP_ABIL)),
    .page_rx  (page_rx),
    .lp_an    (lp_an),
    .ability  (ability)
  );

  an_np_tx #(.W(REG_DATA_W)) u_np (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr && (reg_addr == ADDR_NP_TX)),
    .wdata (reg_wdata),
    .req   (np_tx_valid),
    .page  (np_page)
  );

  assign np_tx_page = np_page;

  always_comb begin
    expan            = '0;
    expan.par_fault  = ~link_up;
    expan.lp_np_able = ability[REG_DATA_W-1];
    expan.np_able    = 1'b1;
    expan.page_rx    = page_rx;
    expan.lp_an_able = lp_an;
  end

  always_comb begin
    case (reg_addr)
      ADDR_LP_ABIL: reg_rdata = ability;
      ADDR_EXPAN:   reg_rdata = expan;
      ADDR_NP_TX:   reg_rdata = np_page;
      ADDR_DEV_ID:  reg_rdata = DEV_ID;
      default:      reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/an_page_status_chk.sv
module an_page_status_chk
  import an_status_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cw_valid,
  input logic                  cw_ready,
  input logic                  flp_seen,
  input logic                  link_up,
  input logic [REG_ADDR_W-1:0] reg_addr,
  input logic                  reg_rd,
  input logic                  reg_wr,
  input logic [REG_DATA_W-1:0] reg_wdata,
  input logic [REG_DATA_W-1:0] reg_rdata,
  input logic                  np_tx_valid,
  input logic [REG_DATA_W-1:0] np_tx_page,
  input logic                  page_rx,
  input logic                  lp_an
);
  // R1
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cw_ready |=> cw_ready);

  // R4
  page_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADDR_LP_ABIL && !cw_valid) |=> !page_rx);

  // R5
  an_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flp_seen |=> lp_an);

  // R5
  an_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lp_an |=> lp_an);

  // R6
  expan_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_EXPAN) |->
      (reg_rdata[15:5] == 11'd0 && reg_rdata[2] && reg_rdata[4] == !link_up));

  // R8
  np_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_NP_TX) |=>
      (np_tx_valid && np_tx_page == $past(reg_wdata)));

  // R8
  np_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    np_tx_valid |-> $past(reg_wr && reg_addr == ADDR_NP_TX));

  // R9
  dev_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_DEV_ID) |-> (reg_rdata == 16'h0005));
endmodule

bind an_page_status an_page_status_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cw_valid    (cw_valid),
  .cw_ready    (cw_ready),
  .flp_seen    (flp_seen),
  .link_up     (link_up),
  .reg_addr    (reg_addr),
  .reg_rd      (reg_rd),
  .reg_wr      (reg_wr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .np_tx_valid (np_tx_valid),
  .np_tx_page  (np_tx_page),
  .page_rx     (page_rx),
  .lp_an       (lp_an)
);

// File: tb/an_page_status_bench.sv
`timescale 1ns/1ps
module an_page_status_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cw_valid = 1'b0;
  logic        cw_ready;
  logic [15:0] cw_data = '0;
  logic        flp_seen = 1'b0;
  logic        link_up = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        reg_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        np_tx_valid;
  logic [15:0] np_tx_page;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  logic [15:0] m_last, m_ab, m_np;
  int          m_run;
  bit          m_page, m_an, m_ready, m_npv;

  always #2.5 clk = ~clk;

  an_page_status u_an_page_status (
    .clk(clk), .rst_n(rst_n), .cw_valid(cw_valid), .cw_ready(cw_ready),
    .cw_data(cw_data), .flp_seen(flp_seen), .link_up(link_up),
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .np_tx_valid(np_tx_valid), .np_tx_page(np_tx_page)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [15:0] e;
    logic [15:0] ex;
    ex = {11'd0, ~link_up, m_ab[15], 1'b1, m_page, m_an};
    case (reg_addr)
      5'h05:   e = m_ab;
      5'h06:   e = ex;
      5'h07:   e = m_np;
      5'h10:   e = 16'h0005;
      default: e = 16'h0000;
    endcase
    if (reg_addr == 5'h06) begin
      chk("R2 page-received bit", {15'd0, reg_rdata[1]}, {15'd0, m_page});
      chk("R5 partner-an bit", {15'd0, reg_rdata[0]}, {15'd0, m_an});
      chk("R6 expansion word", reg_rdata, e);
    end else if (reg_addr == 5'h05) chk("R3 ability read", reg_rdata, e);
    else if (reg_addr == 5'h07) chk("R8 np read", reg_rdata, e);
    else chk("R9 id/unmapped read", reg_rdata, e);
    chk("R1 cw_ready", {15'd0, cw_ready}, {15'd0, m_ready});
    chk("R8 np_tx_valid", {15'd0, np_tx_valid}, {15'd0, m_npv});
    chk("R8 np_tx_page", np_tx_page, m_np);
  endtask

  task automatic model_edge();
    bit hit;
    hit = 1'b0;
    if (!rst_n) begin
      m_last = '0; m_ab = '0; m_np = '0; m_run = 0;
      m_page = 0; m_an = 0; m_ready = 0; m_npv = 0;
      return;
    end
    if (cw_valid && m_ready) begin
      if (m_run > 0 && cw_data == m_last) begin
        if (m_run < 3) begin
          m_run++;
          if (m_run == 3) hit = 1'b1;
        end
      end else begin
        m_run = 1;
        m_last = cw_data;
      end
    end
    if (hit) begin
      m_page = 1'b1;
      m_ab = cw_data;
    end else if (reg_rd && reg_addr == 5'h05) m_page = 1'b0;
    if (flp_seen) m_an = 1'b1;
    m_npv = reg_wr && reg_addr == 5'h07;
    if (m_npv) m_np = reg_wdata;
    m_ready = 1'b1;
  endtask

  task automatic cycle();
    #1 compare();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle();
    cw_valid = 0; flp_seen = 0; reg_rd = 0; reg_wr = 0; reg_addr = 5'h06;
  endtask

  task automatic send(logic [15:0] w);
    cw_valid = 1; cw_data = w; cycle(); idle();
  endtask

  task automatic rd(logic [4:0] a);
    reg_addr = a; reg_rd = 1; cycle(); idle();
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    reg_addr = a; reg_wr = 1; reg_wdata = d; cycle(); idle();
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL R1 watchdog act=timeout exp=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_edge();
    @(negedge clk);
    // R1 reset state
    idle();
    repeat (3) cycle();
    rst_n = 1;
    cycle();
    rd(5'h05); rd(5'h07); rd(5'h06);
    // R5 fast link pulses, sticky
    flp_seen = 1; cycle(); idle(); cycle(); cycle();
    // R2/R3 three identical words with a gap, bit15 set
    link_up = 1;
    send(16'h8421); cycle(); send(16'h8421); send(16'h8421);
    cycle();
    // R2 fourth repeat must not retrigger after clear
    rd(5'h06); rd(5'h05); cycle();
    send(16'h8421); cycle();
    // R2 differing word restarts run
    send(16'h1111); send(16'h1111); send(16'h2222); send(16'h1111); send(16'h1111);
    cycle(); send(16'h1111); cycle();
    rd(5'h05); cycle();
    // R4 collision: read of 0x05 with the completing word
    send(16'h0A0A); send(16'h0A0A);
    reg_addr = 5'h05; reg_rd = 1; cw_valid = 1; cw_data = 16'h0A0A; cycle(); idle();
    cycle(); rd(5'h05); rd(5'h05);
    // R4 read first, completion later
    send(16'h3C3C); send(16'h3C3C); rd(5'h05); send(16'h3C3C); cycle();
    // R6 link toggle
    link_up = 0; cycle(); link_up = 1; cycle();
    // R7 writes to read-only/unmapped
    wr(5'h05, 16'hFFFF); wr(5'h06, 16'hFFFF); wr(5'h10, 16'hFFFF); wr(5'h03, 16'hFFFF);
    rd(5'h05); rd(5'h10); rd(5'h07); cycle();
    // R8 next-page writes, back to back
    wr(5'h07, 16'hBEEF); cycle();
    wr(5'h07, 16'h1234); wr(5'h07, 16'h5678); cycle(); rd(5'h07);
    // R9 unmapped and id reads, no strobe
    reg_addr = 5'h1F; cycle(); reg_addr = 5'h10; cycle(); reg_addr = 5'h00; cycle();
    idle(); cycle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule